// File: doc/BRIEF.md
# Three-Step Block Motion Search Engine

This block estimates the motion of one small square block of pixels. It compares the block against a reference window and returns the displacement of the best match. The current block and the reference window are written into internal storage through a single pixel write port. A start pulse then launches a logarithmic search. Cost is measured as a sum of absolute differences (SAD).

The search evaluates the zero-motion position first. It then runs a fixed number of refinement steps. Each step tests the eight points of a square ring around the current centre. The ring's spacing halves from one step to the next, and the centre moves to the cheapest position found so far. A step cannot begin until the previous step has picked its winner. One candidate costs N cycles of reference reads, one block row per cycle. Each step ends with one extra cycle in which the last comparison settles.

With the default settings (4×4 blocks, 8-bit pixels, three steps), the search range is ±7 and the window is 18×18. A search visits 25 candidates, and the result appears 105 cycles after the start is accepted.

Top module: `tss_motion_search`

## Requirements
- R1: A write with `wr_ref`=0 stores `wr_data` as current-block pixel (row `wr_row`, column `wr_col`). A write with `wr_ref`=1 stores it as reference-window pixel (row `wr_row`, column `wr_col`). Candidate (dx, dy) pairs current pixel (r, c) with window pixel (r+7+dy, c+7+dx).
- R2: `sad` equals the sum over all N×N pixel pairs of |current − reference| at the reported vector, including the all-different case of 4080.
- R3: The reported vector matches a search that proceeds as follows. The centre starts at (0,0), and its cost is computed once. Then, for step sizes 4, 2 and 1 in turn, the eight points at ±step around the current centre are visited in raster order (dy = −1 row first, dx increasing). The best position is updated on strictly lower cost, and each step's winner becomes the next centre.
- R4: On equal cost the earlier candidate is kept, so the centre beats equal neighbours and a neighbour beats later equal neighbours.
- R5: `mv_x` and `mv_y` are signed two's-complement 4-bit values within −7..+7, and both corners ±7 are reachable.
- R6: `done` is high for exactly one cycle per search. `mv_x`, `mv_y` and `sad` change only on the edge that raises `done`, and they hold their values afterwards.
- R7: `busy` rises on the edge that accepts `start` while idle. `done` is high in the cycle that begins 105 rising edges after that edge, and in that cycle `busy` is low.
- R8: A `start` pulse while `busy` is high is ignored: the result and its timing are unchanged.
- R9: After reset, `done` and `busy` are 0, and `mv_x`, `mv_y` and `sad` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Pixel write strobe |
| wr_ref | input | 1 | Write target: 0 current block, 1 reference window |
| wr_row | input | 5 | Pixel row within the selected target |
| wr_col | input | 5 | Pixel column within the selected target |
| wr_data | input | 8 | Pixel value |
| start | input | 1 | Search launch pulse, honoured only while idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| mv_x | output | 4 | Signed horizontal displacement of the best match |
| mv_y | output | 4 | Signed vertical displacement of the best match |
| sad | output | 12 | Cost of the best match |

## Verification
Two events can fall into the same cycle: a search finishing and a new start arriving. The bench raises `start` in the very cycle where `done` is seen high. It expects that start to be accepted, with `busy` high in the next cycle and a second identical result exactly 105 edges later. A start during a running search is also injected mid-step, and that run must match an undisturbed run in both vector and latency. Expected vectors and costs come from a bench search model and an independent SAD function. Both are checked on random images and on directed landscapes that drive the search to each corner or into ties.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN,
    ST_FINISH
  } tss_state_e;
endpackage

// File: rtl/tss_ref_banks.sv
// Reference window split column-wise over N banks so that any N adjacent
// pixels of one row come out in one cycle. One synchronous read per bank.
module tss_ref_banks #(
  parameter int N  = 4,
  parameter int PW = 8,
  parameter int W  = 18,
  parameter int RW = 5
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [RW-1:0]          wr_row,
  input  logic [RW-1:0]          wr_col,
  input  logic [PW-1:0]          wr_data,
  input  logic [RW-1:0]          rd_row,
  input  logic [RW-1:0]          rd_col,
  output logic [N-1:0][PW-1:0]   rd_pix
);
  localparam int LGN   = $clog2(N);
  localparam int CWD   = (W + N - 1) / N;
  localparam int DEPTH = W * CWD;
  localparam int BAW   = $clog2(DEPTH);

  logic [BAW-1:0] wr_addr;
  logic [LGN-1:0] wr_bank;
  logic [BAW-1:0] rd_addr [N];
  logic [PW-1:0]  bank_q  [N];
  logic [LGN-1:0] rot_q;

  assign wr_addr = BAW'(wr_row) * BAW'(CWD) + BAW'(wr_col >> LGN);
  assign wr_bank = wr_col[LGN-1:0];

  // bank b serves the column of the row segment whose low bits equal b
  always_comb begin
    for (int b = 0; b < N; b++) begin
      rd_addr[b] = BAW'(rd_row) * BAW'(CWD)
                 + BAW'((rd_col + RW'(LGN'(LGN'(b) - rd_col[LGN-1:0]))) >> LGN);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_bank
    logic [PW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == LGN'(g)) mem[wr_addr] <= wr_data;
      bank_q[g] <= mem[rd_addr[g]];
    end
  end

  always_ff @(posedge clk) rot_q <= rd_col[LGN-1:0];

  always_comb begin
    for (int k = 0; k < N; k++) rd_pix[k] = bank_q[LGN'(rot_q + LGN'(k))];
  end
endmodule

// File: rtl/tss_sad_row.sv
// Sum of absolute differences across one row of N pixel pairs.
module tss_sad_row #(
  parameter int N  = 4,
  parameter int PW = 8,
  parameter int OW = PW + $clog2(N)
) (
  input  logic [N-1:0][PW-1:0] a,
  input  logic [N-1:0][PW-1:0] b,
  output logic [OW-1:0]        sum
);
  always_comb begin
    sum = '0;
    for (int k = 0; k < N; k++) begin
      sum = sum + OW'((a[k] > b[k]) ? (a[k] - b[k]) : (b[k] - a[k]));
    end
  end
endmodule

// File: rtl/tss_offset.sv
// Raster-ordered ring offset (row above, same row, row below), scaled by step.
module tss_offset #(
  parameter int MVW = 4,
  parameter int SHW = 2
) (
  input  logic [2:0]            idx,
  input  logic [SHW-1:0]        shift,
  output logic signed [MVW-1:0] ox,
  output logic signed [MVW-1:0] oy
);
  logic signed [1:0] ux, uy;

  always_comb begin
    unique case (idx)
      3'd0:    begin ux = -2'sd1; uy = -2'sd1; end
      3'd1:    begin ux =  2'sd0; uy = -2'sd1; end
      3'd2:    begin ux =  2'sd1; uy = -2'sd1; end
      3'd3:    begin ux = -2'sd1; uy =  2'sd0; end
      3'd4:    begin ux =  2'sd1; uy =  2'sd0; end
      3'd5:    begin ux = -2'sd1; uy =  2'sd1; end
      3'd6:    begin ux =  2'sd0; uy =  2'sd1; end
      default: begin ux =  2'sd1; uy =  2'sd1; end
    endcase
    ox = MVW'(ux) <<< shift;
    oy = MVW'(uy) <<< shift;
  end
endmodule

// File: rtl/tss_motion_search.sv
module tss_motion_search #(
  parameter int N      = 4,
  parameter int PW     = 8,
  parameter int NSTEPS = 3,
  localparam int SR    = (1 << NSTEPS) - 1,
  localparam int W     = N + 2 * SR,
  localparam int RW    = $clog2(W),
  localparam int MVW   = NSTEPS + 1,
  localparam int SADW  = $clog2(N * N * ((1 << PW) - 1) + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   wr_ref,
  input  logic [RW-1:0]          wr_row,
  input  logic [RW-1:0]          wr_col,
  input  logic [PW-1:0]          wr_data,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic signed [MVW-1:0]  mv_x,
  output logic signed [MVW-1:0]  mv_y,
  output logic [SADW-1:0]        sad
);
  import tss_pkg::*;

  localparam int LGN  = $clog2(N);
  localparam int ROWW = PW + LGN;
  localparam int GW   = $clog2(NSTEPS + 1);

  tss_state_e state;
  logic [GW-1:0]          grp;
  logic [2:0]             cidx;
  logic [LGN-1:0]         row;
  logic signed [MVW-1:0]  cen_x, cen_y, best_x, best_y;
  logic signed [MVW-1:0]  off_x, off_y, cand_x, cand_y;
  logic [SADW-1:0]        best_sad, acc, total;
  logic                   p_valid, better;
  logic [LGN-1:0]         p_row;
  logic signed [MVW-1:0]  p_dx, p_dy;
  logic [RW-1:0]          rd_row, rd_col;
  logic [N-1:0][PW-1:0]   ref_pix;
  logic [N-1:0][PW-1:0]   cur_rows [N];
  logic [ROWW-1:0]        row_sad;

  // current block kept in flops: a whole row is readable every cycle
  always_ff @(posedge clk) begin
    if (wr_en && !wr_ref) cur_rows[wr_row[LGN-1:0]][wr_col[LGN-1:0]] <= wr_data;
  end

  tss_ref_banks #(.N(N), .PW(PW), .W(W), .RW(RW)) u_ref (
    .clk(clk), .wr_en(wr_en && wr_ref), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .rd_row(rd_row), .rd_col(rd_col), .rd_pix(ref_pix)
  );

  tss_offset #(.MVW(MVW), .SHW(GW)) u_off (
    .idx(cidx), .shift(GW'(NSTEPS) - grp), .ox(off_x), .oy(off_y)
  );

  tss_sad_row #(.N(N), .PW(PW), .OW(ROWW)) u_sad (
    .a(cur_rows[p_row]), .b(ref_pix), .sum(row_sad)
  );

  // group 0 is the lone centre candidate; groups 1..NSTEPS are the rings
  assign cand_x = (grp == '0) ? cen_x : cen_x + off_x;
  assign cand_y = (grp == '0) ? cen_y : cen_y + off_y;
  assign rd_row = RW'(SR) + RW'(row) + RW'(cand_y);
  assign rd_col = RW'(SR) + RW'(cand_x);

  always_comb begin
    total  = ((p_row == '0) ? '0 : acc) + SADW'(row_sad);
    better = p_valid && (p_row == LGN'(N - 1)) && (total < best_sad);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      grp      <= '0;
      cidx     <= '0;
      row      <= '0;
      cen_x    <= '0;
      cen_y    <= '0;
      best_x   <= '0;
      best_y   <= '0;
      best_sad <= '1;
      acc      <= '0;
      p_valid  <= 1'b0;
      p_row    <= '0;
      p_dx     <= '0;
      p_dy     <= '0;
      done     <= 1'b0;
      mv_x     <= '0;
      mv_y     <= '0;
      sad      <= '0;
    end else begin
      done    <= 1'b0;
      p_valid <= (state == ST_ISSUE);
      p_row   <= row;
      p_dx    <= cand_x;
      p_dy    <= cand_y;
      if (p_valid) acc <= total;
      if (better) begin
        best_sad <= total;
        best_x   <= p_dx;
        best_y   <= p_dy;
      end
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_ISSUE;
          grp      <= '0;
          cidx     <= '0;
          row      <= '0;
          cen_x    <= '0;
          cen_y    <= '0;
          best_x   <= '0;
          best_y   <= '0;
          best_sad <= '1;
        end
        ST_ISSUE: begin
          row <= row + 1'b1;
          if (row == LGN'(N - 1)) begin
            row <= '0;
            if (grp == '0 || cidx == 3'd7) begin
              cidx  <= '0;
              state <= ST_DRAIN;
            end else begin
              cidx <= cidx + 3'd1;
            end
          end
        end
        ST_DRAIN: begin
          cen_x <= better ? p_dx : best_x;
          cen_y <= better ? p_dy : best_y;
          if (grp == GW'(NSTEPS)) state <= ST_FINISH;
          else begin
            grp   <= grp + 1'b1;
            state <= ST_ISSUE;
          end
        end
        default: begin
          done  <= 1'b1;
          mv_x  <= best_x;
          mv_y  <= best_y;
          sad   <= best_sad;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/tss_motion_search_chk.sv
module tss_motion_search_chk #(
  parameter int N      = 4,
  parameter int NSTEPS = 3,
  parameter int MVW    = 4,
  parameter int SADW   = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic signed [MVW-1:0] mv_x,
  input logic signed [MVW-1:0] mv_y,
  input logic [SADW-1:0]       sad
);
  localparam int SR  = (1 << NSTEPS) - 1;
  localparam int LAT = (N + 1) + NSTEPS * (8 * N + 1) + 1;

  logic [15:0] cnt;
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start && !busy) cnt <= '0;
    else if (busy) cnt <= cnt + 16'd1;
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(mv_x) && $stable(mv_y) && $stable(sad)));

  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == 16'(LAT)));

  a_r5_mv_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (mv_x >= -SR && mv_x <= SR && mv_y >= -SR && mv_y <= SR));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind tss_motion_search tss_motion_search_chk #(
  .N(N), .NSTEPS(NSTEPS), .MVW(MVW), .SADW(SADW)
) u_chk (.*);

// File: tb/test_tss_motion_search.sv
module test_tss_motion_search;
  localparam int N      = 4;
  localparam int PW     = 8;
  localparam int NSTEPS = 3;
  localparam int SR     = 7;
  localparam int W      = 18;
  localparam int RW     = 5;
  localparam int MVW    = 4;
  localparam int SADW   = 12;
  localparam int LATN   = (N + 1) + NSTEPS * (8 * N + 1) + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_ref = 1'b0, start = 1'b0;
  logic [RW-1:0] wr_row = '0, wr_col = '0;
  logic [PW-1:0] wr_data = '0;
  logic busy, done;
  logic signed [MVW-1:0] mv_x, mv_y;
  logic [SADW-1:0] sad;

  int cur_m [N][N];
  int ref_m [W][W];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tss_motion_search #(.N(N), .PW(PW), .NSTEPS(NSTEPS)) i_tss_motion_search (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ref(wr_ref), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data), .start(start), .busy(busy),
    .done(done), .mv_x(mv_x), .mv_y(mv_y), .sad(sad)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sad_at(input int dx, input int dy);
    int s = 0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        int d = cur_m[r][c] - ref_m[r + SR + dy][c + SR + dx];
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  task automatic model(output int bx, output int by, output int bs);
    bx = 0; by = 0; bs = sad_at(0, 0);
    for (int s = NSTEPS - 1; s >= 0; s--) begin
      int st = 1 << s;
      int cx = bx;
      int cy = by;
      for (int oy = -1; oy <= 1; oy++)
        for (int ox = -1; ox <= 1; ox++)
          if (ox != 0 || oy != 0) begin
            int c = sad_at(cx + ox * st, cy + oy * st);
            if (c < bs) begin bs = c; bx = cx + ox * st; by = cy + oy * st; end
          end
    end
  endtask

  task automatic write_pix(input bit t, input int r, input int c, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_ref = t; wr_row = RW'(r); wr_col = RW'(c); wr_data = PW'(d);
  endtask

  task automatic load_all();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) write_pix(1'b0, r, c, cur_m[r][c]);
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++) write_pix(1'b1, r, c, ref_m[r][c]);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // called right after the negedge that follows the accepting edge
  task automatic wait_done(input int poke, output int lat);
    lat = 1;
    while (!done && lat < 400) begin
      if (lat == 2) chk("R7", "busy during search", int'(busy), 1);
      start = (lat == poke);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  task automatic check_now(input string tag, input int lat, input int ex, input int ey, input int es);
    chk("R7", {tag, " latency"}, lat, LATN);
    chk("R7", {tag, " busy low at done"}, int'(busy), 0);
    chk("R3", {tag, " mv_x"}, int'(mv_x), ex);
    chk("R3", {tag, " mv_y"}, int'(mv_y), ey);
    chk("R2", {tag, " sad vs model"}, int'(sad), es);
    chk("R2", {tag, " sad vs vector"}, int'(sad), sad_at(int'(mv_x), int'(mv_y)));
  endtask

  task automatic search(input string tag, input int poke, output int rx, output int ry, output int rs);
    int ex, ey, es, lat;
    model(ex, ey, es);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(poke, lat);
    check_now(tag, lat, ex, ey, es);
    rx = int'(mv_x); ry = int'(mv_y); rs = int'(sad);
    @(negedge clk);
    chk("R6", {tag, " done one cycle"}, int'(done), 0);
    chk("R6", {tag, " mv_x held"}, int'(mv_x), ex);
    chk("R6", {tag, " sad held"}, int'(sad), es);
  endtask

  task automatic fill_const(input int cv, input int rv);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) cur_m[r][c] = cv;
    for (int r = 0; r < W; r++) for (int c = 0; c < W; c++) ref_m[r][c] = rv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rx, ry, rs, lat, ax, ay, as;
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R9", "reset done", int'(done), 0);
    chk("R9", "reset busy", int'(busy), 0);
    chk("R9", "reset mv_x", int'(mv_x), 0);
    chk("R9", "reset mv_y", int'(mv_y), 0);
    chk("R9", "reset sad", int'(sad), 0);
    rst = 1'b0;

    // R1: single exact match at dx=+4, dy=-4 (asymmetric axes)
    fill_const(200, 0);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) ref_m[r + 3][c + 11] = 200;
    load_all();
    search("R1 placed match", -1, rx, ry, rs);
    chk("R1", "placed mv_x", rx, 4);
    chk("R1", "placed mv_y", ry, -4);
    chk("R1", "placed sad", rs, 0);

    // R4: uniform image, every candidate ties -> centre kept
    fill_const(50, 50);
    load_all();
    search("R4 uniform", -1, rx, ry, rs);
    chk("R4", "uniform mv_x", rx, 0);
    chk("R4", "uniform mv_y", ry, 0);

    // R4: centre worse, all ring points tie at zero -> first raster point
    fill_const(0, 0);
    for (int r = 7; r < 11; r++) for (int c = 7; c < 11; c++) ref_m[r][c] = 9;
    load_all();
    search("R4 ring tie", -1, rx, ry, rs);
    chk("R4", "ring tie mv_x", rx, -4);
    chk("R4", "ring tie mv_y", ry, -4);

    // R2: maximal cost everywhere
    fill_const(255, 0);
    load_all();
    search("R2 max", -1, rx, ry, rs);
    chk("R2", "max sad", rs, 4080);

    // R5: slopes driving the search into each corner
    fill_const(255, 0);
    for (int r = 0; r < W; r++) for (int c = 0; c < W; c++) ref_m[r][c] = (r + c) * 7;
    load_all();
    search("R5 corner+", -1, rx, ry, rs);
    chk("R5", "corner+ mv_x", rx, 7);
    chk("R5", "corner+ mv_y", ry, 7);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) cur_m[r][c] = 0;
    load_all();
    search("R5 corner-", -1, rx, ry, rs);
    chk("R5", "corner- mv_x", rx, -7);
    chk("R5", "corner- mv_y", ry, -7);

    // R3: random images, some with the block copied from a displaced spot
    for (int t = 0; t < 8; t++) begin
      int ox = int'($urandom_range(14)) - 7;
      int oy = int'($urandom_range(14)) - 7;
      for (int r = 0; r < W; r++) for (int c = 0; c < W; c++) ref_m[r][c] = int'($urandom_range(255));
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          cur_m[r][c] = (t < 4) ? int'($urandom_range(255))
                                : (ref_m[r + SR + oy][c + SR + ox] ^ int'($urandom_range(3)));
      load_all();
      search("R3 random", -1, rx, ry, rs);
    end

    // R8: start pulse in the middle of a running search is ignored
    search("R8 reference run", -1, ax, ay, as);
    search("R8 poked run", 40, rx, ry, rs);
    chk("R8", "poked mv_x", rx, ax);
    chk("R8", "poked mv_y", ry, ay);
    chk("R8", "poked sad", rs, as);

    // R7: start in the same cycle as done is accepted back to back
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(-1, lat);
    check_now("R7 first", lat, ax, ay, as);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R7", "chained start accepted", int'(busy), 1);
    chk("R6", "chained done dropped", int'(done), 0);
    wait_done(-1, lat);
    check_now("R7 chained", lat, ax, ay, as);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule